// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Status Flags

This block is the execute stage of a small 16-bit processor core. Each cycle it may accept one operation: an opcode, a destination operand, a source operand, a byte/word selector and a valid strobe. It computes a result and a write-back enable, and it keeps a status register. That register holds carry (C), zero (Z), negative (N) and signed-overflow (V) flags, plus an interrupt-enable bit. Operand fetch, memory and the register file sit outside the block. The result and write-back enable are registered, so they appear one clock after the operation is accepted.

The supported work falls into four groups:
- Two-operand arithmetic: add, subtract, compare and BCD add.
- Two-operand logic and move: and, xor, bit set, bit clear and move.
- One-operand operations on the destination: rotate right or left through carry, arithmetic shift right, byte swap and sign extend.
- Control operations: set or clear individual flags, and enable or disable interrupts.

Each operation has its own flag-update rule, so the rules are spelled out in the requirements below.

Byte mode works on the low 8 bits of each operand. In byte mode the result is zero-extended, and the flags are taken from bit 7.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst_n` is low, `result` is 0, `wb_en` is 0, and all of `flag_c`, `flag_z`, `flag_n`, `flag_v` and `irq_en` are 0.
- R2: An operation is accepted at a rising edge where `op_valid` is 1, and its outputs are visible after that edge. On a cycle with `op_valid` low, `wb_en` goes to 0 and `result` and all flags hold. After any accepted operation that does not write back, `result` also holds.
- R3: Opcode encoding is as follows; codes 22 to 31 have no effect at all.
  - Two-operand: 0 move, 1 add, 2 subtract, 3 compare, 4 BCD add, 5 and, 6 xor, 7 bit set (or), 8 bit clear (dst and not src).
  - One-operand: 9 rotate right through carry, 10 rotate left through carry, 11 arithmetic shift right, 12 byte swap, 13 sign extend.
  - Control: 14 clear C, 15 set C, 16 clear Z, 17 set Z, 18 clear N, 19 set N, 20 disable interrupts, 21 enable interrupts.
- R4: Add gives dst+src, and subtract gives dst+~src+1; both write back. For both, C is the carry out of the top bit (so C=1 means no borrow), Z is set for a zero result, N is the top result bit, and V is set on signed overflow. For example, 0x7FFF+1 gives 0x8000 with V=1, N=1, C=0.
- R5: Compare updates all four flags exactly as subtract does, but leaves `wb_en` at 0.
- R6: BCD add treats every 4-bit nibble as a digit and adds the digits of dst and src plus C. When a digit sum exceeds 9, the digit becomes (sum+6) mod 16 and a carry passes to the next digit. C is the carry out of the top digit, V is 0, and N and Z follow the result.
- R7: And and xor write back. They set N and Z from the result, set C to the inverse of Z, and clear V.
- R8: Move writes the source to the result. Bit set and bit clear write their result. None of these three changes any flag.
- R9: Rotate right through carry shifts C into the top bit, and the old bit 0 goes to C. Rotate left through carry shifts C into bit 0, the old top bit goes to C, and V is the xor of the old top two bits. Both write back and set N and Z from the result; rotate right clears V.
- R10: Arithmetic shift right keeps the top bit and moves the old bit 0 into C. It clears V and sets N and Z from the result.
- R11: Byte swap exchanges the two bytes and leaves the flags alone. Sign extend copies bit 7 into bits 15..8, sets N and Z, sets C to the inverse of Z, and clears V. Both are word-only: in byte mode neither writes back nor changes any flag.
- R12: In byte mode only the low 8 bits of the operands are used. The written result has bits 15..8 equal to 0, and C, N, Z and V are taken at bit 7.
- R13: The control operations force only the named flag or the interrupt enable, and they never assert `wb_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 5 | Operation code (see R3) |
| byte_mode | input | 1 | 1 = byte operation, 0 = word |
| src_opnd | input | 16 | Source operand |
| dst_opnd | input | 16 | Destination operand, also the operand of one-operand operations |
| result | output | 16 | Registered result |
| wb_en | output | 1 | Result of the last accepted operation is to be written back |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| irq_en | output | 1 | Interrupt-enable bit |

## Verification
Within one cycle, the carry flag is both consumed and rewritten: rotate through carry and BCD add read C while producing its next value. In addition, a flag written by one operation is read by the next, back to back. The stimulus keeps `op_valid` high across long random streams, so the carry left by an add, compare or control operation feeds straight into the following rotate or BCD add. The bench model carries its own copy of the flags from step to step and compares every output after each edge, so a stale or early carry shows up as a mismatch.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int BYTE_W = 8;
   localparam int NIB_W  = 4;

   typedef enum logic [4:0] {
      OP_MOV  = 5'd0,
      OP_ADD  = 5'd1,
      OP_SUB  = 5'd2,
      OP_CMP  = 5'd3,
      OP_DADD = 5'd4,
      OP_AND  = 5'd5,
      OP_XOR  = 5'd6,
      OP_BIS  = 5'd7,
      OP_BIC  = 5'd8,
      OP_RRC  = 5'd9,
      OP_RLC  = 5'd10,
      OP_RRA  = 5'd11,
      OP_SWAP = 5'd12,
      OP_SEXT = 5'd13,
      OP_CLRC = 5'd14,
      OP_SETC = 5'd15,
      OP_CLRZ = 5'd16,
      OP_SETZ = 5'd17,
      OP_CLRN = 5'd18,
      OP_SETN = 5'd19,
      OP_DINT = 5'd20,
      OP_EINT = 5'd21
   } alu_op_e;

   // bit 0 carry, bit 1 zero, bit 2 negative, bit 3 overflow
   typedef struct packed {
      logic v;
      logic n;
      logic z;
      logic c;
   } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
   import alu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              sub_sel,
   input  logic              dec_sel,
   input  logic              byte_mode,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output alu_flags_t        flags
);

   localparam int NIBS   = DATA_W / NIB_W;
   localparam int B_NIBS = BYTE_W / NIB_W;
   localparam int HI_W   = DATA_W - BYTE_W;

   generate
      if (DATA_W % NIB_W != 0) begin : g_bad_width
         $error("alu_addsub: DATA_W must be a multiple of the digit width");
      end
   endgenerate

   // binary path
   logic [DATA_W-1:0] b_eff;
   logic              cin_bin;
   logic [DATA_W:0]   sum_w;
   logic [BYTE_W:0]   sum_b;
   logic [DATA_W-1:0] bin_res;
   logic              bin_c;
   logic              sgn_a, sgn_b, sgn_r;
   logic              bin_v;

   assign b_eff   = sub_sel ? ~b : b;
   assign cin_bin = sub_sel;
   assign sum_w   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_bin};
   assign sum_b   = {1'b0, a[BYTE_W-1:0]} + {1'b0, b_eff[BYTE_W-1:0]}
                  + {{BYTE_W{1'b0}}, cin_bin};
   assign bin_res = byte_mode ? {{HI_W{1'b0}}, sum_b[BYTE_W-1:0]} : sum_w[DATA_W-1:0];
   assign bin_c   = byte_mode ? sum_b[BYTE_W] : sum_w[DATA_W];
   assign sgn_a   = byte_mode ? a[BYTE_W-1]       : a[DATA_W-1];
   assign sgn_b   = byte_mode ? b_eff[BYTE_W-1]   : b_eff[DATA_W-1];
   assign sgn_r   = byte_mode ? bin_res[BYTE_W-1] : bin_res[DATA_W-1];
   assign bin_v   = (sgn_a == sgn_b) && (sgn_r != sgn_a);

   // decimal path: one digit adder per nibble, carries chained
   logic [NIBS:0]       dc;
   logic [DATA_W-1:0]   dec_full;
   logic [DATA_W-1:0]   dec_res;
   logic                dec_c;

   assign dc[0] = cin;

   generate
      for (genvar g = 0; g < NIBS; g++) begin : g_digit
         logic [NIB_W:0] nsum;
         assign nsum = {1'b0, a[g*NIB_W +: NIB_W]} + {1'b0, b[g*NIB_W +: NIB_W]}
                     + {{NIB_W{1'b0}}, dc[g]};
         assign dc[g+1] = (nsum > 5'd9);
         assign dec_full[g*NIB_W +: NIB_W] = dc[g+1] ? (nsum[NIB_W-1:0] + 4'd6)
                                                     : nsum[NIB_W-1:0];
      end
   endgenerate

   assign dec_res = byte_mode ? {{HI_W{1'b0}}, dec_full[BYTE_W-1:0]} : dec_full;
   assign dec_c   = byte_mode ? dc[B_NIBS] : dc[NIBS];

   // merge
   assign res     = dec_sel ? dec_res : bin_res;
   assign flags.c = dec_sel ? dec_c : bin_c;
   assign flags.v = dec_sel ? 1'b0 : bin_v;
   assign flags.z = (res == '0);
   assign flags.n = byte_mode ? res[BYTE_W-1] : res[DATA_W-1];

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
   import alu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  alu_op_e           op,
   input  logic              byte_mode,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output alu_flags_t        flags
);

   localparam int HI_W = DATA_W - BYTE_W;
   localparam int HALF = DATA_W / 2;

   logic [DATA_W-1:0] mask;
   logic              top_bit, next_bit;
   logic [DATA_W-1:0] rrc_r, rlc_r, rra_r, swp_r, sxt_r;

   assign mask     = byte_mode ? {{HI_W{1'b0}}, {BYTE_W{1'b1}}} : {DATA_W{1'b1}};
   assign top_bit  = byte_mode ? a[BYTE_W-1] : a[DATA_W-1];
   assign next_bit = byte_mode ? a[BYTE_W-2] : a[DATA_W-2];

   assign rrc_r = byte_mode ? {{HI_W{1'b0}}, cin, a[BYTE_W-1:1]}
                            : {cin, a[DATA_W-1:1]};
   assign rlc_r = byte_mode ? {{HI_W{1'b0}}, a[BYTE_W-2:0], cin}
                            : {a[DATA_W-2:0], cin};
   assign rra_r = byte_mode ? {{HI_W{1'b0}}, a[BYTE_W-1], a[BYTE_W-1:1]}
                            : {a[DATA_W-1], a[DATA_W-1:1]};
   assign swp_r = {a[HALF-1:0], a[DATA_W-1:HALF]};
   assign sxt_r = {{HI_W{a[BYTE_W-1]}}, a[BYTE_W-1:0]};

   logic c_out, v_out;

   always_comb begin
      res   = '0;
      c_out = 1'b0;
      v_out = 1'b0;
      unique case (op)
         OP_MOV:  res = b & mask;
         OP_AND:  res = a & b & mask;
         OP_XOR:  res = (a ^ b) & mask;
         OP_BIS:  res = (a | b) & mask;
         OP_BIC:  res = a & ~b & mask;
         OP_RRC:  begin res = rrc_r; c_out = a[0]; end
         OP_RLC:  begin res = rlc_r; c_out = top_bit; v_out = top_bit ^ next_bit; end
         OP_RRA:  begin res = rra_r; c_out = a[0]; end
         OP_SWAP: res = swp_r;
         OP_SEXT: res = sxt_r;
         default: res = '0;
      endcase
      if (op == OP_AND || op == OP_XOR || op == OP_SEXT) begin
         c_out = (res != '0);
      end
   end

   assign flags.c = c_out;
   assign flags.v = v_out;
   assign flags.z = (res == '0);
   assign flags.n = byte_mode ? res[BYTE_W-1] : res[DATA_W-1];

endmodule

// File: rtl/alu_status.sv
module alu_status
   import alu_pkg::*;
#(
   parameter int NFLAGS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NFLAGS-1:0] upd_mask,
   input  logic [NFLAGS-1:0] upd_val,
   input  logic [NFLAGS-1:0] set_mask,
   input  logic [NFLAGS-1:0] clr_mask,
   input  logic              gie_set,
   input  logic              gie_clr,
   output logic [NFLAGS-1:0] flags_q,
   output logic              gie_q
);

   generate
      if (NFLAGS != $bits(alu_flags_t)) begin : g_bad_nflags
         $error("alu_status: NFLAGS must match the flag record");
      end
   endgenerate

   generate
      for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)              flags_q[i] <= 1'b0;
            else if (set_mask[i])    flags_q[i] <= 1'b1;
            else if (clr_mask[i])    flags_q[i] <= 1'b0;
            else if (upd_mask[i])    flags_q[i] <= upd_val[i];
         end

         assert_flag_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
            set_mask[i] |=> flags_q[i]);
         assert_flag_clr_R13: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[i] && !set_mask[i]) |=> !flags_q[i]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       gie_q <= 1'b0;
      else if (gie_set) gie_q <= 1'b1;
      else if (gie_clr) gie_q <= 1'b0;
   end

   assert_gie_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(gie_set && gie_clr));
   assert_gie_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!gie_set && !gie_clr) |=> $stable(gie_q));

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [4:0]        op_code,
   input  logic              byte_mode,
   input  logic [DATA_W-1:0] src_opnd,
   input  logic [DATA_W-1:0] dst_opnd,
   output logic [DATA_W-1:0] result,
   output logic              wb_en,
   output logic              flag_c,
   output logic              flag_z,
   output logic              flag_n,
   output logic              flag_v,
   output logic              irq_en
);

   localparam int NFLAGS = $bits(alu_flags_t);

   generate
      if (DATA_W < 2 * BYTE_W || DATA_W % BYTE_W != 0) begin : g_bad_width
         $error("alu_flag_unit: DATA_W must be a byte multiple of at least two bytes");
      end
   endgenerate

   alu_op_e    op;
   alu_flags_t flags_q, ar_flags, bo_flags, nxt_flags;
   logic [DATA_W-1:0] ar_res, bo_res, nxt_res;
   logic       gie_q;

   assign op = alu_op_e'(op_code);

   // ---------------- datapaths ----------------
   alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .sub_sel   (op == OP_SUB || op == OP_CMP),
      .dec_sel   (op == OP_DADD),
      .byte_mode (byte_mode),
      .a         (dst_opnd),
      .b         (src_opnd),
      .cin       (flags_q.c),
      .res       (ar_res),
      .flags     (ar_flags)
   );

   alu_bitops #(.DATA_W(DATA_W)) u_bitops (
      .op        (op),
      .byte_mode (byte_mode),
      .a         (dst_opnd),
      .b         (src_opnd),
      .cin       (flags_q.c),
      .res       (bo_res),
      .flags     (bo_flags)
   );

   // ---------------- decode ----------------
   logic is_arith, wr, upd_all;
   logic [NFLAGS-1:0] set_m, clr_m;
   logic gie_set, gie_clr;

   always_comb begin
      is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP) || (op == OP_DADD);
      wr       = 1'b0;
      upd_all  = 1'b0;
      set_m    = '0;
      clr_m    = '0;
      gie_set  = 1'b0;
      gie_clr  = 1'b0;
      case (op)
         OP_MOV, OP_BIS, OP_BIC:                  wr = 1'b1;
         OP_ADD, OP_SUB, OP_DADD, OP_AND, OP_XOR,
         OP_RRC, OP_RLC, OP_RRA:                  begin wr = 1'b1; upd_all = 1'b1; end
         OP_CMP:                                  upd_all = 1'b1;
         OP_SWAP:                                 wr = !byte_mode;
         OP_SEXT:                                 begin wr = !byte_mode; upd_all = !byte_mode; end
         OP_CLRC: clr_m[0] = 1'b1;
         OP_SETC: set_m[0] = 1'b1;
         OP_CLRZ: clr_m[1] = 1'b1;
         OP_SETZ: set_m[1] = 1'b1;
         OP_CLRN: clr_m[2] = 1'b1;
         OP_SETN: set_m[2] = 1'b1;
         OP_DINT: gie_clr  = 1'b1;
         OP_EINT: gie_set  = 1'b1;
         default: ;
      endcase
   end

   assign nxt_res   = is_arith ? ar_res   : bo_res;
   assign nxt_flags = is_arith ? ar_flags : bo_flags;

   // ---------------- registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result <= '0;
         wb_en  <= 1'b0;
      end else begin
         wb_en <= op_valid && wr;
         if (op_valid && wr) result <= nxt_res;
      end
   end

   logic [NFLAGS-1:0] st_q;

   alu_status #(.NFLAGS(NFLAGS)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_mask ({NFLAGS{op_valid && upd_all}}),
      .upd_val  (nxt_flags),
      .set_mask (set_m & {NFLAGS{op_valid}}),
      .clr_mask (clr_m & {NFLAGS{op_valid}}),
      .gie_set  (op_valid && gie_set),
      .gie_clr  (op_valid && gie_clr),
      .flags_q  (st_q),
      .gie_q    (gie_q)
   );

   assign flags_q = alu_flags_t'(st_q);
   assign flag_c  = flags_q.c;
   assign flag_z  = flags_q.z;
   assign flag_n  = flags_q.n;
   assign flag_v  = flags_q.v;
   assign irq_en  = gie_q;

   // ---------------- assertions ----------------
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!wb_en && $stable(result) && $stable(flags_q)));

   assert_add_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !byte_mode && (op == OP_ADD || op == OP_SUB))
         |=> (flag_z == (result == '0)));

   assert_cmp_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_CMP) |=> (!wb_en && $stable(result)));

   assert_mov_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op == OP_MOV || op == OP_BIS || op == OP_BIC)) |=> $stable(flags_q));

   assert_word_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && byte_mode && (op == OP_SWAP || op == OP_SEXT))
         |=> (!wb_en && $stable(flags_q) && $stable(result)));

   assert_byte_zext_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && byte_mode) |=> (!wb_en || result[DATA_W-1:BYTE_W] == '0));

   assert_ctrl_no_wb_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code >= 5'd14) |=> !wb_en);

endmodule

// File: tb/alu_flag_unit_tb.sv
`timescale 1ns/1ps
module alu_flag_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [4:0]  op_code = '0;
   logic        byte_mode = 1'b0;
   logic [15:0] src_opnd = '0;
   logic [15:0] dst_opnd = '0;
   logic [15:0] result;
   logic        wb_en, flag_c, flag_z, flag_n, flag_v, irq_en;

   always #2.5 clk = ~clk;

   alu_flag_unit #(.DATA_W(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .byte_mode(byte_mode), .src_opnd(src_opnd), .dst_opnd(dst_opnd),
      .result(result), .wb_en(wb_en), .flag_c(flag_c), .flag_z(flag_z),
      .flag_n(flag_n), .flag_v(flag_v), .irq_en(irq_en)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // model state
   logic [15:0] m_res = '0;
   bit m_wb = 0, m_c = 0, m_z = 0, m_n = 0, m_v = 0, m_gie = 0;

   function automatic bit bat(int val, int pos);
      return bit'((val >> pos) & 1);
   endfunction

   task automatic model(input bit vld, input logic [4:0] op, input bit bm,
                        input logic [15:0] s, input logic [15:0] d);
      int w, mask, sb, x, sv, full, r, cy, t;
      bit do_wb, do_fl, nc, nv;
      m_wb = 0;
      if (!vld) return;
      w = bm ? 8 : 16; mask = (1 << w) - 1; sb = w - 1;
      x = int'(d) & mask; sv = int'(s) & mask;
      do_wb = 0; do_fl = 0; nc = 0; nv = 0; r = 0;
      case (op)
         5'd0: begin r = sv; do_wb = 1; end
         5'd1: begin
            full = x + sv; r = full & mask; nc = bat(full, w);
            nv = (bat(x, sb) == bat(sv, sb)) && (bat(r, sb) != bat(x, sb));
            do_wb = 1; do_fl = 1;
         end
         5'd2, 5'd3: begin
            full = x + ((~int'(s)) & mask) + 1; r = full & mask; nc = bat(full, w);
            nv = (bat(x, sb) != bat(sv, sb)) && (bat(r, sb) != bat(x, sb));
            do_wb = (op == 5'd2); do_fl = 1;
         end
         5'd4: begin
            cy = int'(m_c);
            for (int i = 0; i < w / 4; i++) begin
               t = ((x >> (4*i)) & 15) + ((sv >> (4*i)) & 15) + cy;
               if (t > 9) begin t = (t + 6) & 15; cy = 1; end else cy = 0;
               r = r | (t << (4*i));
            end
            nc = bit'(cy); do_wb = 1; do_fl = 1;
         end
         5'd5: begin r = x & sv; nc = (r != 0); do_wb = 1; do_fl = 1; end
         5'd6: begin r = x ^ sv; nc = (r != 0); do_wb = 1; do_fl = 1; end
         5'd7: begin r = x | sv; do_wb = 1; end
         5'd8: begin r = x & ~sv & mask; do_wb = 1; end
         5'd9: begin r = (int'(m_c) << sb) | (x >> 1); nc = bat(x, 0); do_wb = 1; do_fl = 1; end
         5'd10: begin
            r = ((x << 1) | int'(m_c)) & mask; nc = bat(x, sb);
            nv = bat(x, sb) ^ bat(x, sb - 1); do_wb = 1; do_fl = 1;
         end
         5'd11: begin r = (x & (1 << sb)) | (x >> 1); nc = bat(x, 0); do_wb = 1; do_fl = 1; end
         5'd12: if (!bm) begin r = ((int'(d) & 255) << 8) | (int'(d) >> 8); do_wb = 1; end
         5'd13: if (!bm) begin
            r = bat(int'(d), 7) ? ((int'(d) & 255) | 'hFF00) : (int'(d) & 255);
            nc = (r != 0); do_wb = 1; do_fl = 1;
         end
         5'd14: m_c = 0;
         5'd15: m_c = 1;
         5'd16: m_z = 0;
         5'd17: m_z = 1;
         5'd18: m_n = 0;
         5'd19: m_n = 1;
         5'd20: m_gie = 0;
         5'd21: m_gie = 1;
         default: ;
      endcase
      if (do_fl) begin
         m_c = nc; m_v = nv; m_z = (r == 0); m_n = bat(r, sb);
      end
      if (do_wb) m_res = 16'(r);
      m_wb = do_wb;
   endtask

   function automatic string req_of(input logic [4:0] op, input bit bm, input bit vld);
      if (!vld) return "R2";
      if (bm && op <= 5'd11) return "R12";
      case (op)
         5'd0, 5'd7, 5'd8: return "R8";
         5'd1, 5'd2:       return "R4";
         5'd3:             return "R5";
         5'd4:             return "R6";
         5'd5, 5'd6:       return "R7";
         5'd9, 5'd10:      return "R9";
         5'd11:            return "R10";
         5'd12, 5'd13:     return "R11";
         default:          return (op <= 5'd21) ? "R13" : "R3";
      endcase
   endfunction

   task automatic compare(input string tag);
      n_cmp++;
      if (result !== m_res || wb_en !== m_wb || flag_c !== m_c || flag_z !== m_z ||
          flag_n !== m_n || flag_v !== m_v || irq_en !== m_gie) begin
         n_bad++;
         $display("FAIL %s: got res=%h wb=%b cznv=%b%b%b%b gie=%b, expected res=%h wb=%b cznv=%b%b%b%b gie=%b",
                  tag, result, wb_en, flag_c, flag_z, flag_n, flag_v, irq_en,
                  m_res, m_wb, m_c, m_z, m_n, m_v, m_gie);
      end
   endtask

   // called at a negative edge; leaves the bench at the next negative edge
   task automatic step(input bit vld, input logic [4:0] op, input bit bm,
                       input logic [15:0] s, input logic [15:0] d, input string tag);
      op_valid = vld; op_code = op; byte_mode = bm; src_opnd = s; dst_opnd = d;
      model(vld, op, bm, s, d);
      @(negedge clk);
      compare(tag);
   endtask

   function automatic logic [15:0] rand_bcd();
      logic [15:0] v;
      for (int i = 0; i < 4; i++) v[4*i +: 4] = 4'($urandom_range(0, 9));
      return v;
   endfunction

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd20251);
      repeat (3) @(negedge clk);
      compare("R1");                              // reset state
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // directed corner cases
      step(1, 5'd1, 0, 16'h0001, 16'h7FFF, "R4");   // 0x8000, V N
      step(1, 5'd1, 0, 16'h0001, 16'hFFFF, "R4");   // 0, C Z
      step(1, 5'd2, 0, 16'h1234, 16'h1234, "R4");   // 0, C=1 no borrow
      step(1, 5'd2, 0, 16'h8000, 16'h0000, "R4");   // signed overflow
      step(1, 5'd3, 0, 16'h0002, 16'h0001, "R5");   // borrow, no wb
      step(1, 5'd15, 0, 16'h0, 16'h0, "R13");
      step(1, 5'd0, 0, 16'hABCD, 16'h0, "R8");      // flags untouched
      step(1, 5'd4, 0, 16'h0000, 16'h9999, "R6");   // +C -> 0000, C
      step(1, 5'd4, 1, 16'h0055, 16'h1245, "R6");   // byte BCD
      step(0, 5'd1, 0, 16'hFFFF, 16'hFFFF, "R2");   // idle hold
      step(1, 5'd1, 1, 16'h0001, 16'h337F, "R12");  // byte 0x80, V
      step(1, 5'd9, 0, 16'h0, 16'h0001, "R9");      // rotate out bit 0
      step(1, 5'd10, 0, 16'h0, 16'h4000, "R9");     // V from top bits
      step(1, 5'd11, 0, 16'h0, 16'h8003, "R10");
      step(1, 5'd12, 1, 16'h0, 16'h1234, "R11");    // ignored in byte mode
      step(1, 5'd13, 1, 16'h0, 16'h0080, "R11");    // ignored in byte mode
      step(1, 5'd13, 0, 16'h0, 16'h0080, "R11");    // 0xFF80
      step(1, 5'd12, 0, 16'h0, 16'h1234, "R11");    // 0x3412
      step(1, 5'd21, 0, 16'h0, 16'h0, "R13");
      step(1, 5'd5, 0, 16'h0F0F, 16'hF0F0, "R7");   // zero, C=0
      step(1, 5'd19, 0, 16'h0, 16'h0, "R13");
      step(1, 5'd20, 0, 16'h0, 16'h0, "R13");
      step(1, 5'd26, 0, 16'h1111, 16'h2222, "R3");  // unassigned

      // constrained random, valid mostly high
      for (int k = 0; k < 3000; k++) begin
         logic [4:0]  op;
         logic [15:0] s, d;
         bit vld, bm;
         op  = 5'($urandom_range(0, 23));
         vld = ($urandom_range(0, 99) < 85);
         bm  = ($urandom_range(0, 3) == 0);
         if (op == 5'd4) begin s = rand_bcd(); d = rand_bcd(); end
         else begin
            s = 16'($urandom);
            d = 16'($urandom);
            if ($urandom_range(0, 7) == 0) s = 16'h0001;
            if ($urandom_range(0, 7) == 0) d = 16'h7FFF;
         end
         step(vld, op, bm, s, d, req_of(op, bm, vld));
      end

      op_valid = 1'b0;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got no completion, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule